// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block is a small SPI master that carries out one short serial-flash command each time it is started. Software first loads a command word and a data word. The command word holds the opcode in its low byte and a 24-bit flash address above it. Software then writes a control word that gives how many bytes to send and how many to receive. The engine selects the flash, shifts out the transmit bytes, and then clocks in the receive bytes. When it finishes, it packs the received bytes into the data word.

The link runs in clock mode 0 only: SCK idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. There is a single chip select. There is no full duplex: receive bytes are clocked only after every transmit byte has gone out. A busy flag in the control word covers the whole command. A one-cycle done pulse marks its end. The SCK half period, in system clocks, is set by a divider register.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the lines are idle and the registers are set as follows. spi_cs_n=1, spi_sck=0, spi_mosi=0, busy=0 and done=0. The command, data and control words read as zero. The divider reads DEF_HALF (2).
- R2: The register map on reg_addr is 0 = command word, 1 = data word, 2 = control, 3 = divider. In the command word, bits 7:0 are the opcode and bits 31:8 are the flash address. A write to address 0 or 1 reads back unchanged.
- R3: The control field layout is tx count in [3:0] and rx count in [7:4], plus a mode field in [9:8] and a select field in [11:10]. A valid control write starts a command. The next cycle reads back the two counts, with busy in bit 16. Busy stays set until chip select is released.
- R4: A control write is rejected, and nothing starts, if any of these hold: mode is not 0, select is not 0, tx count is 0, tx count is above 8, or rx count is above 4. A rejected write clears the stored counts to zero.
- R5: Transmit bytes go out in this order: opcode, then address bits 23:16, 15:8 and 7:0, then data-word bytes 7:0, 15:8, 23:16 and 31:24. The tx count sets how many of these are sent, counting from the opcode.
- R6: Bits go out MSB first. SCK idles low. MOSI changes only while SCK falls, and is held while SCK is high.
- R7: Chip select goes low on the cycle after the start. SCK first rises one half period later. After the last falling edge, chip select is released one half period later.
- R8: Receive bits are sampled on rising SCK edges, and only after all transmit bits; MOSI is 0 while they are clocked. Each received byte is assembled MSB first. Receive byte j is stored in data-word bits 8j+7:8j, and the unreceived upper bytes are zero. When the rx count is 0, the data word is left unchanged.
- R9: The divider gives the SCK half period in system clocks. A written value of 0 is used as 1.
- R10: done pulses high for exactly one cycle, on the cycle in which busy first reads 0.
- R11: While busy is set, writes to any register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
A wrong edge counter or bit index shows up on SCK or MOSI within one half period. It appears as a misplaced edge, a wrong bit, or a MOSI change while SCK is high. The cycle-accurate model compares every cycle, so such a fault is caught at once. A wrong receive index shows up only in the data word, after the command ends. Those faults are caught by reading the word after the done pulse, with receive patterns that have a distinct value in each byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int MAX_TX = 8;
  localparam int MAX_RX = 4;
  localparam int CNT_W  = 4;
  localparam int BITS_MAX = 8 * (MAX_TX + MAX_RX);
  localparam int EDGE_W = $clog2(2 * BITS_MAX + 2);
  localparam int IDX_W  = EDGE_W - 1;
  localparam int BUSY_BIT = 16;

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_CTL  = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  typedef struct packed {
    logic [CNT_W-1:0] rx;
    logic [CNT_W-1:0] tx;
  } counts_t;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DEF_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             busy,
  input  logic             rx_load,
  input  logic [31:0]      rx_word,
  output logic [31:0]      cmd_q,
  output logic [31:0]      data_q,
  output counts_t          cnt_q,
  output logic [DIV_W-1:0] half_q,
  output logic             start
);
  logic [31:0]      cmd_d, data_d;
  counts_t          cnt_d;
  logic [DIV_W-1:0] half_d;
  logic             wr_ok, ctl_ok;
  logic [CNT_W-1:0] w_tx, w_rx;

  assign w_tx  = wdata[CNT_W-1:0];
  assign w_rx  = wdata[2*CNT_W-1:CNT_W];
  assign wr_ok = wr && !busy;
  assign ctl_ok = (wdata[11:8] == 4'd0) && (w_tx != '0) &&
                  (w_tx <= CNT_W'(MAX_TX)) && (w_rx <= CNT_W'(MAX_RX));
  assign start = wr_ok && (addr == A_CTL) && ctl_ok;

  always_comb begin
    cmd_d  = cmd_q;
    data_d = data_q;
    cnt_d  = cnt_q;
    half_d = half_q;
    if (rx_load) data_d = rx_word;
    if (wr_ok) begin
      unique case (addr)
        A_CMD:  cmd_d  = wdata;
        A_DATA: data_d = wdata;
        A_CTL:  cnt_d  = ctl_ok ? counts_t'({w_rx, w_tx}) : '0;
        default: half_d = (wdata[DIV_W-1:0] == '0) ? DIV_W'(1) : wdata[DIV_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      half_q <= DIV_W'(DEF_HALF);
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end
endmodule

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start || tick) cnt_d = half - DIV_W'(1);
    else if (run)      cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        tick,
  input  counts_t     cnt,
  input  logic [63:0] tx_vec,
  input  logic        miso,
  output logic        busy,
  output logic        cs_n,
  output logic        sck,
  output logic        mosi,
  output logic        done,
  output logic        rx_load,
  output logic [31:0] rx_word
);
  logic              busy_q, busy_d, sck_q, sck_d, done_q, done_d;
  logic [EDGE_W-1:0] edge_q, edge_d, last_edge;
  logic [31:0]       rx_q, rx_d;
  logic [IDX_W-1:0]  idx, tx_bits, r;
  logic [5:0]        sel;
  logic [4:0]        pos;
  logic              last;

  assign idx       = edge_q[EDGE_W-1:1];
  assign tx_bits   = IDX_W'(cnt.tx) << 3;
  assign last_edge = EDGE_W'({1'b0, cnt.tx} + {1'b0, cnt.rx}) << 4;
  assign last      = busy_q && tick && (edge_q == last_edge);
  assign sel       = 6'(IDX_W'(63) - idx);
  assign r         = idx - tx_bits;
  assign pos       = {r[4:3], ~r[2:0]};

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    edge_d = edge_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      edge_d = '0;
      rx_d   = '0;
    end else if (busy_q && tick) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        edge_d = edge_q + EDGE_W'(1);
        sck_d  = ~edge_q[0];
        if (!edge_q[0] && (idx >= tx_bits)) rx_d[pos] = miso;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      edge_q <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      edge_q <= edge_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign busy    = busy_q;
  assign cs_n    = ~busy_q;
  assign sck     = sck_q;
  assign done    = done_q;
  assign mosi    = busy_q && (idx < tx_bits) && tx_vec[sel];
  assign rx_load = last && (cnt.rx != '0);
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DEF_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        busy,
  output logic        done
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [31:0]      cmd_q, data_q, rx_word;
  counts_t          cnt_q;
  logic [DIV_W-1:0] half_q;
  logic             start, tick, rx_load;
  logic [63:0]      tx_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  spi_cmd_regs #(.DIV_W(DIV_W), .DEF_HALF(DEF_HALF)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .rx_load(rx_load), .rx_word(rx_word),
    .cmd_q(cmd_q), .data_q(data_q), .cnt_q(cnt_q), .half_q(half_q),
    .start(start)
  );

  spi_cmd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .start(start), .run(busy),
    .half(half_q), .tick(tick)
  );

  assign tx_vec = {cmd_q[7:0], cmd_q[31:8],
                   data_q[7:0], data_q[15:8], data_q[23:16], data_q[31:24]};

  spi_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .tick(tick), .cnt(cnt_q),
    .tx_vec(tx_vec), .miso(spi_miso), .busy(busy), .cs_n(spi_cs_n),
    .sck(spi_sck), .mosi(spi_mosi), .done(done), .rx_load(rx_load),
    .rx_word(rx_word)
  );

  always_comb begin
    unique case (reg_addr)
      A_CMD:  reg_rdata = cmd_q;
      A_DATA: reg_rdata = data_q;
      A_CTL:  reg_rdata = {15'd0, busy, 8'd0, cnt_q.rx, cnt_q.tx};
      default: reg_rdata = 32'(half_q);
    endcase
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sck,
  input logic mosi
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck && !mosi)); // R1
  AST_SEL_DURING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n); // R7
  AST_SCK_LOW_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) || $rose(cs_n)) |-> !sck); // R7
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mosi)) |-> $fell(sck)); // R6
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R10
  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi)
);

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sck, spi_mosi, busy, done;
  logic        spi_miso = 1'b0;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_cmd_engine u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Behavioural reference: one command with tx/rx counts, half period h.
  task automatic run_cmd(input string req, input logic [31:0] cmd, input logic [31:0] dat,
                         input int tx, input int rx, input int h,
                         input logic [31:0] rxpat, input bit poke);
    logic [7:0]  txb[8];
    logic [31:0] v;
    int hh, nb, total, k, idx, r;
    logic e_busy, e_sck, e_mosi, e_miso;
    txb[0] = cmd[7:0];   txb[1] = cmd[31:24]; txb[2] = cmd[23:16]; txb[3] = cmd[15:8];
    txb[4] = dat[7:0];   txb[5] = dat[15:8];  txb[6] = dat[23:16];  txb[7] = dat[31:24];
    hh = (h == 0) ? 1 : h;
    nb = 8 * (tx + rx);
    total = hh * (2 * nb + 1);
    wr(2'd3, 32'(h)); wr(2'd0, cmd); wr(2'd1, dat);
    wr(2'd2, 32'(tx | (rx << 4)));
    for (int t = 0; t <= total + 1; t++) begin
      k = t / hh; idx = k / 2;
      e_busy = (t < total);
      e_sck  = e_busy && (k % 2 == 1);
      e_mosi = e_busy && (idx < 8 * tx) && txb[idx / 8][7 - idx % 8];
      r = idx - 8 * tx;
      e_miso = (idx >= 8 * tx) && (idx < nb) && rxpat[8 * (r / 8) + 7 - r % 8];
      spi_miso = e_miso;
      if (t == 0) begin
        rd(2'd2, v);
        chk("R3", "control readback", v, 32'(tx | (rx << 4)) | 32'h10000);
      end
      if (poke && t == 2) begin
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = ~cmd;
      end
      if (poke && t == 3) begin
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = ~dat;
      end
      #1;
      chk("R3", "busy", 32'(busy), 32'(e_busy));
      chk("R7", "cs_n", 32'(spi_cs_n), 32'(!e_busy));
      chk("R6", "sck", 32'(spi_sck), 32'(e_sck));
      chk("R5", "mosi", 32'(spi_mosi), 32'(e_mosi));
      chk("R10", "done", 32'(done), 32'(t == total));
      @(negedge clk);
      reg_wr = 1'b0;
    end
    spi_miso = 1'b0;
    rd(2'd1, v);
    if (rx > 0) chk("R8", "rx data packing", v, rxpat & ((rx == 4) ? 32'hffffffff : ((32'd1 << (8 * rx)) - 1)));
    else chk("R8", "data unchanged", v, dat);
    if (poke) begin
      rd(2'd0, v);
      chk("R11", "cmd write ignored while busy", v, cmd);
    end
    rd(2'd3, v);
    chk("R9", "divider readback", v, 32'(hh));
    $display("  done: %s tx=%0d rx=%0d h=%0d", req, tx, rx, h);
  endtask

  task automatic reject(input logic [31:0] ctl, input string what);
    logic [31:0] v;
    wr(2'd2, 32'h0000_0011);
    wait (!busy);
    @(negedge clk); @(negedge clk);
    wr(2'd2, ctl);
    #1;
    chk("R4", {what, " busy"}, 32'(busy), 32'd0);
    chk("R4", {what, " cs_n"}, 32'(spi_cs_n), 32'd1);
    rd(2'd2, v);
    chk("R4", {what, " counts cleared"}, v, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "cs_n", 32'(spi_cs_n), 32'd1);
    chk("R1", "sck", 32'(spi_sck), 32'd0);
    chk("R1", "mosi", 32'(spi_mosi), 32'd0);
    chk("R1", "busy/done", {30'd0, busy, done}, 32'd0);
    rd(2'd0, v); chk("R1", "cmd", v, 32'd0);
    rd(2'd1, v); chk("R1", "data", v, 32'd0);
    rd(2'd2, v); chk("R1", "ctl", v, 32'd0);
    rd(2'd3, v); chk("R1", "divider", v, 32'd2);
    @(negedge clk);
    wr(2'd0, 32'hA1B2C3D4); rd(2'd0, v); chk("R2", "cmd word", v, 32'hA1B2C3D4);
    wr(2'd1, 32'h55AA0FF0); rd(2'd1, v); chk("R2", "data word", v, 32'h55AA0FF0);
    @(negedge clk);
    run_cmd("R8 status read", 32'h0000_0005, 32'h0, 1, 1, 2, 32'h0000_00C3, 1'b0);
    run_cmd("R9 write enable div0", 32'h0000_0006, 32'h1234_5678, 1, 0, 0, 32'h0, 1'b0);
    run_cmd("R5 program", 32'h12_34_56_02, 32'hDE_AD_BE_EF, 8, 0, 3, 32'h0, 1'b1);
    run_cmd("R8 read 4", 32'h00_80_01_03, 32'h0, 4, 4, 1, 32'h8C_4B_2A_19, 1'b0);
    run_cmd("R8 partial", 32'h0000_009F, 32'hFFFF_FFFF, 2, 3, 2, 32'hF0_E1_D2_C3, 1'b0);
    reject(32'h0000_0111, "mode");
    reject(32'h0000_0411, "select");
    reject(32'h0000_0010, "tx zero");
    reject(32'h0000_0019, "tx above 8");
    reject(32'h0000_0051, "rx above 4");
    summary();
  end
endmodule